// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the fifteen 32-bit general registers of a processor core, r0 through r14, together with the extra copies that let each processor mode keep private registers. The stack pointer (r13) and link register (r14) are shadowed once per mode group, with user and system mode sharing one group. The five registers r8 to r12 have one alternate set that is live only while the core sits in fast-interrupt mode. The program counter is not stored here. A read of index 15 returns an external PC input.

The execute stage reads through two combinational read ports and writes through one write port. To switch modes it pulses a request that carries the mode being left and the mode being entered. In that single clock the block parks the outgoing live copies in their banks and loads the incoming ones. It also stores the current status word in the saved-status slot of the entered mode, when that mode has such a slot. The saved-status slots can be read through a port indexed by mode.

Modes use a 3-bit code: user 0, fast-interrupt 1, normal interrupt 2, supervisor 3, abort 4, undefined 5, system 6. Code 7 behaves like user.

Top module: `banked_regfile`

## Requirements
- R1: A synchronous reset clears every live, banked and saved-status register to zero and sets the current mode to supervisor (code 3).
- R2: Both read ports are combinational. Index 0 to 14 returns the live register, and index 15 returns `pc_in`.
- R3: A write with `wr_en` high and `wr_idx` in 0 to 14 is visible on the read ports from the next cycle. A write to index 15 changes nothing.
- R4: On a mode change, live r13 and r14 are stored in the leaving mode's group slot, and the entering mode's group slot is readable as r13 and r14 in the next cycle.
- R5: User and system modes share one r13/r14 group, so switching between them leaves r13 and r14 unchanged.
- R6: Entering fast-interrupt mode from any other mode stores live r8 to r12 in the normal set and loads them from the fast-interrupt set. r0 to r7 are unaffected.
- R7: Leaving fast-interrupt mode stores live r8 to r12 in the fast-interrupt set and restores the normal set.
- R8: A change between two modes that are both not fast-interrupt, or from fast-interrupt to itself, leaves r8 to r12 unchanged.
- R9: On a mode change into fast-interrupt, normal interrupt, supervisor, abort or undefined mode, `status_in` is stored in that mode's saved-status slot, readable on `ss_data` with `ss_mode` set to that mode. User and system modes have no slot, and `ss_data` reads zero for them.
- R10: A write issued in the same cycle as a mode change is applied to the leaving mode's view before the swap.
- R11: `cur_mode` takes the value of `mode_to` in the cycle after a mode change request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx_a | input | 4 | Read port A register index |
| rd_data_a | output | 32 | Read port A data |
| rd_idx_b | input | 4 | Read port B register index |
| rd_data_b | output | 32 | Read port B data |
| wr_en | input | 1 | Write enable |
| wr_idx | input | 4 | Write register index |
| wr_data | input | 32 | Write data |
| pc_in | input | 32 | Value returned for index 15 |
| mode_req | input | 1 | Mode change request |
| mode_from | input | 3 | Mode being left, must equal `cur_mode` |
| mode_to | input | 3 | Mode being entered |
| status_in | input | 32 | Status word saved on a mode change |
| ss_mode | input | 3 | Mode whose saved-status slot is read |
| ss_data | output | 32 | Saved-status slot contents |
| cur_mode | output | 3 | Current mode |

## Verification
The bench walks every ordered pair of the seven modes, including a mode changing to itself. Between changes it fills r0 and r8 to r14 with fresh values, so each bank ends up holding distinct data. A design that indexed the r13/r14 bank by raw mode instead of by group would lose the stack pointer on user/system switches. A design that swapped r8 to r12 on every change, or on a fast-interrupt-to-itself change, would return the other set's contents. Writes that coincide with a mode change are aimed at r13 and at the high registers. A design that dropped such a write, or applied it after the swap, would corrupt the entered mode's bank instead of the left one. Saved-status reads for user and system must stay zero however many changes occur.

// File: rtl/bank_pkg.sv
package bank_pkg;
    localparam int DW      = 32;
    localparam int NLIVE   = 15;
    localparam int NGRP    = 6;
    localparam int NHI     = 5;
    localparam int HI_BASE = 8;
    localparam int NSS     = NGRP - 1;
    localparam int IDXW    = $clog2(NLIVE + 1);
    localparam int MW      = 3;
    localparam int GW      = $clog2(NGRP);

    typedef enum logic [MW-1:0] {
        MODE_USR = 3'd0,
        MODE_FIQ = 3'd1,
        MODE_IRQ = 3'd2,
        MODE_SVC = 3'd3,
        MODE_ABT = 3'd4,
        MODE_UND = 3'd5,
        MODE_SYS = 3'd6,
        MODE_RSV = 3'd7
    } mode_e;

    typedef struct packed {
        logic  req;
        mode_e from;
        mode_e to;
    } swap_t;

    // Bank group of a mode: user, system and the reserved code share group 0.
    function automatic logic [GW-1:0] grp_of(input mode_e m);
        case (m)
            MODE_FIQ: grp_of = GW'(1);
            MODE_IRQ: grp_of = GW'(2);
            MODE_SVC: grp_of = GW'(3);
            MODE_ABT: grp_of = GW'(4);
            MODE_UND: grp_of = GW'(5);
            default:  grp_of = GW'(0);
        endcase
    endfunction

    function automatic logic has_saved(input mode_e m);
        has_saved = (grp_of(m) != GW'(0));
    endfunction

    function automatic logic [GW-1:0] saved_slot(input mode_e m);
        saved_slot = grp_of(m) - GW'(1);
    endfunction
endpackage

// File: rtl/live_regs.sv
module live_regs
    import bank_pkg::*;
#(
    parameter int W     = DW,
    parameter int N     = NLIVE,
    parameter int HB    = HI_BASE,
    parameter int NH    = NHI,
    parameter int IW    = IDXW
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [W-1:0]          wr_data,
    input  logic                  swap,
    input  logic                  hi_swap,
    input  logic [NH-1:0][W-1:0]  hi_load,
    input  logic [W-1:0]          sp_load,
    input  logic [W-1:0]          lr_load,
    output logic [N-1:0][W-1:0]   merged,
    output logic [N-1:0][W-1:0]   live
);
    logic [N-1:0][W-1:0] nxt;

    // Write applied first: the outgoing mode sees its own write.
    always_comb begin
        merged = live;
        if (wr_en && (wr_idx < IW'(N))) begin
            merged[wr_idx] = wr_data;
        end
    end

    always_comb begin
        nxt = merged;
        if (swap) begin
            nxt[N-2] = sp_load;
            nxt[N-1] = lr_load;
            if (hi_swap) begin
                for (int i = 0; i < NH; i++) begin
                    nxt[HB+i] = hi_load[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) live <= '0;
        else     live <= nxt;
    end
endmodule

// File: rtl/sp_lr_bank.sv
module sp_lr_bank
    import bank_pkg::*;
#(
    parameter int W  = DW,
    parameter int NG = NGRP,
    parameter int GWD = GW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           swap,
    input  logic [GWD-1:0] grp_from,
    input  logic [GWD-1:0] grp_to,
    input  logic [W-1:0]   sp_cur,
    input  logic [W-1:0]   lr_cur,
    output logic [W-1:0]   sp_load,
    output logic [W-1:0]   lr_load
);
    logic [W-1:0] sp_q [NG];
    logic [W-1:0] lr_q [NG];

    generate
        for (genvar g = 0; g < NG; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    sp_q[g] <= '0;
                    lr_q[g] <= '0;
                end else if (swap && (grp_from == GWD'(g))) begin
                    sp_q[g] <= sp_cur;
                    lr_q[g] <= lr_cur;
                end
            end
        end
    endgenerate

    // Same group on both sides: the slot is being rewritten this cycle, forward.
    always_comb begin
        if (grp_to == grp_from) begin
            sp_load = sp_cur;
            lr_load = lr_cur;
        end else if (grp_to < GWD'(NG)) begin
            sp_load = sp_q[grp_to];
            lr_load = lr_q[grp_to];
        end else begin
            sp_load = '0;
            lr_load = '0;
        end
    end
endmodule

// File: rtl/hi_bank.sv
module hi_bank
    import bank_pkg::*;
#(
    parameter int W  = DW,
    parameter int NH = NHI
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 enter,
    input  logic                 leave,
    input  logic [NH-1:0][W-1:0] cur,
    output logic [NH-1:0][W-1:0] load
);
    logic [NH-1:0][W-1:0] norm_q;
    logic [NH-1:0][W-1:0] fast_q;

    generate
        for (genvar i = 0; i < NH; i++) begin : g_hi
            always_ff @(posedge clk) begin
                if (rst) begin
                    norm_q[i] <= '0;
                    fast_q[i] <= '0;
                end else begin
                    if (enter) norm_q[i] <= cur[i];
                    if (leave) fast_q[i] <= cur[i];
                end
            end
            assign load[i] = enter ? fast_q[i] : norm_q[i];
        end
    endgenerate
endmodule

// File: rtl/status_bank.sv
module status_bank
    import bank_pkg::*;
#(
    parameter int W  = DW,
    parameter int NS = NSS,
    parameter int SW = GW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [SW-1:0] wr_slot,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_valid,
    input  logic [SW-1:0] rd_slot,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] slot_q [NS];

    generate
        for (genvar s = 0; s < NS; s++) begin : g_ss
            always_ff @(posedge clk) begin
                if (rst)                              slot_q[s] <= '0;
                else if (wr && (wr_slot == SW'(s)))   slot_q[s] <= wr_data;
            end
        end
    endgenerate

    always_comb begin
        if (rd_valid && (rd_slot < SW'(NS))) rd_data = slot_q[rd_slot];
        else                                 rd_data = '0;
    end
endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [IDXW-1:0] rd_idx_a,
    output logic [DW-1:0]   rd_data_a,
    input  logic [IDXW-1:0] rd_idx_b,
    output logic [DW-1:0]   rd_data_b,
    input  logic            wr_en,
    input  logic [IDXW-1:0] wr_idx,
    input  logic [DW-1:0]   wr_data,
    input  logic [DW-1:0]   pc_in,
    input  logic            mode_req,
    input  logic [MW-1:0]   mode_from,
    input  logic [MW-1:0]   mode_to,
    input  logic [DW-1:0]   status_in,
    input  logic [MW-1:0]   ss_mode,
    output logic [DW-1:0]   ss_data,
    output logic [MW-1:0]   cur_mode
);
    swap_t                     sw;
    logic [NLIVE-1:0][DW-1:0]  merged;
    logic [NLIVE-1:0][DW-1:0]  live;
    logic [NHI-1:0][DW-1:0]    hi_cur;
    logic [NHI-1:0][DW-1:0]    hi_load;
    logic [DW-1:0]             sp_load;
    logic [DW-1:0]             lr_load;
    logic                      fiq_enter;
    logic                      fiq_leave;
    mode_e                     mode_q;

    assign sw.req  = mode_req;
    assign sw.from = mode_e'(mode_from);
    assign sw.to   = mode_e'(mode_to);

    assign fiq_enter = sw.req && (sw.to == MODE_FIQ) && (sw.from != MODE_FIQ);
    assign fiq_leave = sw.req && (sw.from == MODE_FIQ) && (sw.to != MODE_FIQ);

    always_comb begin
        for (int i = 0; i < NHI; i++) hi_cur[i] = merged[HI_BASE+i];
    end

    live_regs u_live (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
        .swap(sw.req), .hi_swap(fiq_enter | fiq_leave), .hi_load(hi_load),
        .sp_load(sp_load), .lr_load(lr_load),
        .merged(merged), .live(live)
    );

    sp_lr_bank u_splr (
        .clk(clk), .rst(rst), .swap(sw.req),
        .grp_from(grp_of(sw.from)), .grp_to(grp_of(sw.to)),
        .sp_cur(merged[NLIVE-2]), .lr_cur(merged[NLIVE-1]),
        .sp_load(sp_load), .lr_load(lr_load)
    );

    hi_bank u_hi (
        .clk(clk), .rst(rst), .enter(fiq_enter), .leave(fiq_leave),
        .cur(hi_cur), .load(hi_load)
    );

    status_bank u_ss (
        .clk(clk), .rst(rst),
        .wr(sw.req && has_saved(sw.to)), .wr_slot(saved_slot(sw.to)), .wr_data(status_in),
        .rd_valid(has_saved(mode_e'(ss_mode))), .rd_slot(saved_slot(mode_e'(ss_mode))),
        .rd_data(ss_data)
    );

    always_ff @(posedge clk) begin
        if (rst)         mode_q <= MODE_SVC;
        else if (sw.req) mode_q <= sw.to;
    end
    assign cur_mode = mode_q;

    always_comb begin
        rd_data_a = (rd_idx_a == IDXW'(NLIVE)) ? pc_in : live[rd_idx_a];
        rd_data_b = (rd_idx_b == IDXW'(NLIVE)) ? pc_in : live[rd_idx_b];
    end
endmodule

// File: rtl/banked_regfile_chk.sv
module banked_regfile_chk
    import bank_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic [IDXW-1:0] rd_idx_a,
    input logic [DW-1:0]   rd_data_a,
    input logic            wr_en,
    input logic [IDXW-1:0] wr_idx,
    input logic [DW-1:0]   wr_data,
    input logic [DW-1:0]   pc_in,
    input logic            mode_req,
    input logic [MW-1:0]   mode_from,
    input logic [MW-1:0]   mode_to,
    input logic [DW-1:0]   status_in,
    input logic [MW-1:0]   ss_mode,
    input logic [DW-1:0]   ss_data,
    input logic [MW-1:0]   cur_mode
);
    assert_reset_mode_R1: assert property (@(posedge clk)
        rst |=> (cur_mode == MODE_SVC));

    assert_pc_route_R2: assert property (@(posedge clk) disable iff (rst)
        (rd_idx_a == IDXW'(NLIVE)) |-> (rd_data_a == pc_in));

    assert_write_visible_R3: assert property (@(posedge clk) disable iff (rst)
        ($past(wr_en && !mode_req) && (rd_idx_a == $past(wr_idx)) && (rd_idx_a != IDXW'(NLIVE)))
        |-> (rd_data_a == $past(wr_data)));

    assert_hi_kept_R8: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_req && !wr_en && (mode_from != MODE_FIQ) && (mode_to != MODE_FIQ))
         && (rd_idx_a >= IDXW'(8)) && (rd_idx_a <= IDXW'(12)) && (rd_idx_a == $past(rd_idx_a)))
        |-> (rd_data_a == $past(rd_data_a)));

    assert_status_saved_R9: assert property (@(posedge clk) disable iff (rst)
        ($past(mode_req) && (ss_mode == $past(mode_to)) && has_saved(mode_e'(ss_mode)))
        |-> (ss_data == $past(status_in)));

    assert_mode_follow_R11: assert property (@(posedge clk) disable iff (rst)
        mode_req |=> (cur_mode == $past(mode_to)));
endmodule

bind banked_regfile banked_regfile_chk u_chk (.*);

// File: tb/test_banked_regfile.sv
module test_banked_regfile;
    import bank_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic [3:0]      rd_idx_a = '0, rd_idx_b = '0, wr_idx = '0;
    logic [31:0]     rd_data_a, rd_data_b, wr_data = '0, pc_in = 32'h0800_1234;
    logic            wr_en = 1'b0, mode_req = 1'b0;
    logic [2:0]      mode_from = 3'd3, mode_to = 3'd3, ss_mode = '0, cur_mode;
    logic [31:0]     status_in = '0, ss_data;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic [31:0] m_live [15];
    logic [31:0] m_sp [6];
    logic [31:0] m_lr [6];
    logic [31:0] m_norm [5];
    logic [31:0] m_fast [5];
    logic [31:0] m_ss [5];
    int          m_mode;

    banked_regfile i_banked_regfile (
        .clk(clk), .rst(rst),
        .rd_idx_a(rd_idx_a), .rd_data_a(rd_data_a),
        .rd_idx_b(rd_idx_b), .rd_data_b(rd_data_b),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .pc_in(pc_in),
        .mode_req(mode_req), .mode_from(mode_from), .mode_to(mode_to),
        .status_in(status_in), .ss_mode(ss_mode), .ss_data(ss_data),
        .cur_mode(cur_mode)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int grp(input int m);
        if (m >= 1 && m <= 5) return m;
        return 0;
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] exp_rd(input int idx);
        return (idx == 15) ? pc_in : m_live[idx];
    endfunction

    task automatic verify_regs(input string tag);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            rd_idx_a = 4'(i);
            rd_idx_b = 4'(15 - i);
            #1;
            check({tag, " port A"}, rd_data_a, exp_rd(i));
            check({tag, " port B"}, rd_data_b, exp_rd(15 - i));
        end
    endtask

    task automatic verify_ss(input string tag);
        for (int m = 0; m < 7; m++) begin
            @(negedge clk);
            ss_mode = 3'(m);
            #1;
            check(tag, ss_data, (grp(m) != 0) ? m_ss[grp(m)-1] : 32'h0);
        end
    endtask

    task automatic write_reg(input int idx, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 4'(idx); wr_data = d;
        if (idx < 15) m_live[idx] = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic change_mode(input int to, input bit do_wr, input int widx,
                               input logic [31:0] wd, input logic [31:0] st);
        int from = m_mode;
        @(negedge clk);
        mode_req = 1'b1; mode_from = 3'(from); mode_to = 3'(to); status_in = st;
        wr_en = do_wr; wr_idx = 4'(widx); wr_data = wd;
        if (do_wr && widx < 15) m_live[widx] = wd;
        m_sp[grp(from)] = m_live[13];
        m_lr[grp(from)] = m_live[14];
        m_live[13] = m_sp[grp(to)];
        m_live[14] = m_lr[grp(to)];
        if (to == 1 && from != 1) begin
            for (int i = 0; i < 5; i++) begin
                m_norm[i] = m_live[8+i];
                m_live[8+i] = m_fast[i];
            end
        end else if (from == 1 && to != 1) begin
            for (int i = 0; i < 5; i++) begin
                m_fast[i] = m_live[8+i];
                m_live[8+i] = m_norm[i];
            end
        end
        if (grp(to) != 0) m_ss[grp(to)-1] = st;
        m_mode = to;
        @(negedge clk);
        mode_req = 1'b0; wr_en = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int step = 0;
        string tg;
        for (int i = 0; i < 15; i++) m_live[i] = '0;
        for (int i = 0; i < 6; i++) begin m_sp[i] = '0; m_lr[i] = '0; end
        for (int i = 0; i < 5; i++) begin
            m_norm[i] = '0; m_fast[i] = '0; m_ss[i] = '0;
        end
        m_mode = 3;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        check("R1 mode", {29'd0, cur_mode}, 32'd3);
        verify_regs("R1");
        verify_ss("R1");

        // R3: fill every register, including ignored index 15
        for (int i = 0; i < 16; i++) write_reg(i, 32'hA000_0000 + 32'(i * 32'h111));
        verify_regs("R3 R2");

        // R10: write r13 in the same cycle as leaving supervisor
        change_mode(2, 1'b1, 13, 32'hDEAD_0010, 32'h1111_0002);
        verify_regs("R10");
        change_mode(3, 1'b0, 0, 32'h0, 32'h1111_0003);
        @(negedge clk); rd_idx_a = 4'd13; #1;
        check("R10 r13 kept in leaving bank", rd_data_a, 32'hDEAD_0010);

        // Sweep every ordered mode pair
        for (int a = 0; a < 7; a++) begin
            for (int b = 0; b < 7; b++) begin
                for (int leg = 0; leg < 2; leg++) begin
                    int to = (leg == 0) ? a : b;
                    int from = m_mode;
                    bit cw = (step % 3 == 0);
                    int widx = (step % 2 == 0) ? 13 : 8 + (step % 5);
                    if ((from == 0 || from == 6) && (to == 0 || to == 6)) tg = "R5";
                    else if (to == 1 && from != 1)                           tg = "R6";
                    else if (from == 1 && to != 1)                           tg = "R7";
                    else                                                     tg = "R4 R8";
                    if (cw) tg = {tg, " R10"};
                    pc_in = 32'h0800_0000 + 32'(step * 4);
                    change_mode(to, cw, widx, 32'hC000_0000 + 32'(step),
                                32'h5000_0000 + 32'(step * 16));
                    check("R11 mode", {29'd0, cur_mode}, 32'(to));
                    verify_regs(tg);
                    verify_ss("R9");
                    write_reg(0, 32'h7000_0000 + 32'(step));
                    for (int r = 8; r < 15; r++)
                        write_reg(r, 32'h4000_0000 + 32'(step * 256 + r));
                    step++;
                end
            end
        end
        verify_regs("R3 R4");

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule